// File: doc/BRIEF.md
# Posted Refresh Debt Scheduler

This block decides when an SDRAM controller should spend a cycle on an auto-refresh command. An interval timer marks the passage of each average refresh period, and every mark adds one refresh to an outstanding balance. While the balance is non-zero the block raises a soft request that the controller may serve whenever the command bus is otherwise quiet. When the balance reaches the number of refreshes the memory tolerates being postponed, a hard request tells the controller to stop normal traffic and refresh now.

The controller closes all banks on its own, issues the refresh, and reports it with a one-cycle acknowledge. Each accepted acknowledge retires one refresh from the balance and opens a hold-off window equal to the refresh cycle time. During that window a busy flag is high and both requests are held low, so no further refresh or row activation is started too early. Several owed refreshes can be paid back to back, separated only by the hold-off. Dropping the enable wipes both the balance and the partial interval.

Top module: `refresh_debt_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, req_soft, req_hard, busy and debt_overflow are all low.
- R2: With enable high, one refresh is added to the balance every INTERVAL_CYC enabled clock edges; req_soft first becomes high after the INTERVAL_CYC-th enabled edge, and not before.
- R3: Outside the hold-off window req_soft is high when the balance is at least one, and req_hard is high exactly when the balance equals MAX_OWED; after MAX_OWED intervals req_hard is high.
- R4: An accepted acknowledge (ack_refresh high while req_soft is high) removes exactly one refresh from the balance, so k accepted acknowledges clear a balance of k.
- R5: After an accepted acknowledge, busy is high for exactly TRFC_CYC cycles, and req_soft and req_hard stay low for as long as busy is high.
- R6: An acknowledge while req_soft is low (no balance, or inside the hold-off window) is ignored: the balance does not change and busy is not raised.
- R7: An interval ending while the balance is at MAX_OWED and no refresh is accepted leaves the balance at MAX_OWED and makes debt_overflow high for exactly one cycle.
- R8: When an interval ends on the same edge as an accepted acknowledge, the balance is unchanged.
- R9: A cycle with enable low clears the balance to zero and restarts the interval, so the next refresh is added INTERVAL_CYC enabled edges after enable returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the interval timer; low clears balance and timer |
| ack_refresh | input | 1 | One-cycle pulse: the controller has issued a refresh |
| req_soft | output | 1 | At least one refresh is owed and the hold-off has ended |
| req_hard | output | 1 | The balance is at the postponement limit; refresh at once |
| busy | output | 1 | Refresh cycle time still running after the last refresh |
| debt_overflow | output | 1 | One-cycle pulse: an interval ended with the balance already full |

## Verification
The embedded properties take for granted that the controller acknowledges only refreshes it was asked for, so a decrement is checked only when the balance is non-zero and an acknowledge is only treated as accepted while req_soft is up. The directed stimulus keeps to that contract in its ordinary scenarios and breaks it only on purpose, with acknowledges at zero balance and inside the hold-off, where the block must filter them. Every acknowledge is a single-cycle pulse driven on the falling clock edge, and intervals are aligned with acknowledges by counting enabled edges from the moment enable rises.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;

  // Bits needed to hold the values 0 .. n-1 (never less than one bit).
  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned INTERVAL_CYC = 1300
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  output logic tick
);
  localparam int unsigned CW = ref_sched_pkg::width_for(INTERVAL_CYC);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt_q;

  // Interval ends on the edge where the counter holds its last value.
  assign tick = enable && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: the counter never runs past the end of the interval
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R2: two interval ends are never adjacent when the interval is longer than one cycle
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (INTERVAL_CYC > 1) && tick |=> !tick);

  // R9: a disabled cycle restarts the interval from zero
  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    !enable |=> cnt_q == '0);

endmodule

// File: rtl/ref_debt_counter.sv
module ref_debt_counter #(
  parameter int unsigned MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic tick,
  input  logic take,
  output logic [ref_sched_pkg::width_for(MAX_OWED + 1)-1:0] debt_q,
  output logic [ref_sched_pkg::width_for(MAX_OWED + 1)-1:0] debt_d,
  output logic ovf_q
);
  localparam int unsigned DW = ref_sched_pkg::width_for(MAX_OWED + 1);
  localparam logic [DW-1:0] FULL = DW'(MAX_OWED);

  always_comb begin
    debt_d = debt_q;
    if (!enable) begin
      debt_d = '0;
    end else begin
      unique case ({tick, take})
        2'b10:   if (debt_q != FULL) debt_d = debt_q + 1'b1;
        2'b01:   if (debt_q != '0)   debt_d = debt_q - 1'b1;
        default: debt_d = debt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      debt_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      debt_q <= debt_d;
      ovf_q  <= enable && tick && !take && (debt_q == FULL);
    end
  end

  // R3: the balance never exceeds the postponement limit
  a_r3_debt_bound: assert property (@(posedge clk) disable iff (rst)
    debt_q <= FULL);

  // R2: an interval end below the limit adds exactly one
  a_r2_increment: assert property (@(posedge clk) disable iff (rst)
    enable && tick && !take && (debt_q != FULL) |=> debt_q == $past(debt_q) + DW'(1));

  // R4: an accepted refresh removes exactly one
  a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
    enable && take && !tick && (debt_q != '0) |=> debt_q == $past(debt_q) - DW'(1));

  // R8: interval end and refresh on the same edge cancel
  a_r8_cancel: assert property (@(posedge clk) disable iff (rst)
    enable && take && tick |=> debt_q == $past(debt_q));

  // R7: overflow is flagged only with the balance held at the limit
  a_r7_overflow_at_full: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> debt_q == FULL);

  // R9: disabling empties the balance
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    !enable |=> debt_q == '0);

endmodule

// File: rtl/ref_holdoff.sv
module ref_holdoff #(
  parameter int unsigned TRFC_CYC = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy_q,
  output logic busy_d
);
  localparam int unsigned HW = ref_sched_pkg::width_for(TRFC_CYC + 1);
  localparam logic [HW-1:0] LOAD = HW'(TRFC_CYC);

  logic [HW-1:0] hcnt_q;
  logic [HW-1:0] hcnt_d;

  always_comb begin
    if (start) begin
      hcnt_d = LOAD;
    end else if (hcnt_q != '0) begin
      hcnt_d = hcnt_q - 1'b1;
    end else begin
      hcnt_d = '0;
    end
    busy_d = (hcnt_d != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt_q <= '0;
      busy_q <= 1'b0;
    end else begin
      hcnt_q <= hcnt_d;
      busy_q <= busy_d;
    end
  end

  // R5: an accepted refresh opens the window
  a_r5_window_opens: assert property (@(posedge clk) disable iff (rst)
    (TRFC_CYC > 0) && start |=> busy_q);

  // R5: the window counts down one per cycle
  a_r5_window_counts: assert property (@(posedge clk) disable iff (rst)
    (hcnt_q != '0) && !start |=> hcnt_q == $past(hcnt_q) - HW'(1));

  // R5: busy mirrors a running window
  a_r5_busy_tracks: assert property (@(posedge clk) disable iff (rst)
    busy_q == (hcnt_q != '0));

endmodule

// File: rtl/refresh_debt_sched.sv
module refresh_debt_sched #(
  parameter int unsigned INTERVAL_CYC = 1300,
  parameter int unsigned TRFC_CYC     = 12,
  parameter int unsigned MAX_OWED     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic ack_refresh,
  output logic req_soft,
  output logic req_hard,
  output logic busy,
  output logic debt_overflow
);
  localparam int unsigned DW = ref_sched_pkg::width_for(MAX_OWED + 1);
  localparam logic [DW-1:0] FULL = DW'(MAX_OWED);

  logic          tick;
  logic          take;
  logic          busy_d;
  logic [DW-1:0] debt_q;
  logic [DW-1:0] debt_d;
  logic          soft_q;
  logic          hard_q;

  // A refresh only counts when it answers a visible request.
  assign take = ack_refresh && soft_q;

  ref_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .tick   (tick)
  );

  ref_debt_counter #(.MAX_OWED(MAX_OWED)) u_debt (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .tick   (tick),
    .take   (take),
    .debt_q (debt_q),
    .debt_d (debt_d),
    .ovf_q  (debt_overflow)
  );

  ref_holdoff #(.TRFC_CYC(TRFC_CYC)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .start  (take),
    .busy_q (busy),
    .busy_d (busy_d)
  );

  // Requests are registered from next-state values so they line up with busy.
  always_ff @(posedge clk) begin
    if (rst) begin
      soft_q <= 1'b0;
      hard_q <= 1'b0;
    end else begin
      soft_q <= (debt_d != '0) && !busy_d;
      hard_q <= (debt_d == FULL) && !busy_d;
    end
  end

  assign req_soft = soft_q;
  assign req_hard = hard_q;

  // R5: no request is visible during the hold-off window
  a_r5_masked: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_soft && !req_hard);

  // R3: the hard request always comes with a soft one
  a_r3_hard_implies_soft: assert property (@(posedge clk) disable iff (rst)
    req_hard |-> req_soft);

  // R3: a soft request means a balance is really owed
  a_r3_soft_has_debt: assert property (@(posedge clk) disable iff (rst)
    req_soft |-> debt_q != '0);

  // R6: a stray acknowledge does not start a window
  a_r6_stray_ack: assert property (@(posedge clk) disable iff (rst)
    ack_refresh && !req_soft && !busy |=> !busy);

  // R7: overflow is a single-cycle pulse when the interval is longer than one cycle
  a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
    (INTERVAL_CYC > 1) && debt_overflow |=> !debt_overflow);

endmodule

// File: tb/refresh_debt_sched_test.sv
module refresh_debt_sched_test;
  localparam int unsigned IV = 200;
  localparam int unsigned TR = 4;
  localparam int unsigned MX = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic ack_refresh = 1'b0;
  logic req_soft, req_hard, busy, debt_overflow;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  refresh_debt_sched #(.INTERVAL_CYC(IV), .TRFC_CYC(TR), .MAX_OWED(MX)) uut (
    .clk           (clk),
    .rst           (rst),
    .enable        (enable),
    .ack_refresh   (ack_refresh),
    .req_soft      (req_soft),
    .req_hard      (req_hard),
    .busy          (busy),
    .debt_overflow (debt_overflow)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack_refresh = 1'b1;
    @(negedge clk);
    ack_refresh = 1'b0;
  endtask

  task automatic start_fresh();
    @(negedge clk);
    rst = 1'b1; enable = 1'b0; ack_refresh = 1'b0;
    wait_cyc(3);
    rst = 1'b0;
  endtask

  // R1: outputs quiet in and right after reset
  task automatic t_reset();
    start_fresh();
    chk("R1", "soft in reset", req_soft, 0);
    chk("R1", "hard in reset", req_hard, 0);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "overflow in reset", debt_overflow, 0);
    wait_cyc(1);
    chk("R1", "soft after reset", req_soft, 0);
    chk("R1", "busy after reset", busy, 0);
  endtask

  // R2, R3, R7, R4: fill to the limit, overflow once, pay one back
  task automatic t_fill_and_overflow();
    start_fresh();
    enable = 1'b1;
    wait_cyc(IV - 1);
    chk("R2", "soft one edge early", req_soft, 0);
    wait_cyc(1);
    chk("R2", "soft after first interval", req_soft, 1);
    chk("R3", "hard at balance 1", req_hard, 0);
    wait_cyc(7 * IV - 1);
    chk("R3", "hard at balance 7", req_hard, 0);
    wait_cyc(1);
    chk("R3", "hard at balance 8", req_hard, 1);
    wait_cyc(IV - 1);
    chk("R7", "overflow before ninth interval", debt_overflow, 0);
    wait_cyc(1);
    chk("R7", "overflow at ninth interval", debt_overflow, 1);
    chk("R7", "hard held at limit", req_hard, 1);
    wait_cyc(1);
    chk("R7", "overflow one cycle only", debt_overflow, 0);
    pulse_ack();
    wait_cyc(TR);
    chk("R4", "hard drops after one refresh", req_hard, 0);
    chk("R4", "soft remains at balance 7", req_soft, 1);
  endtask

  // R4, R5: pay back three refreshes back to back
  task automatic t_paydown();
    start_fresh();
    enable = 1'b1;
    wait_cyc(3 * IV);
    chk("R3", "soft at balance 3", req_soft, 1);
    for (int i = 0; i < 3; i++) begin
      pulse_ack();
      chk("R5", "busy right after refresh", busy, 1);
      chk("R5", "soft masked in window", req_soft, 0);
      wait_cyc(TR - 1);
      chk("R5", "busy at last window cycle", busy, 1);
      wait_cyc(1);
      chk("R5", "busy ends after window", busy, 0);
      chk("R4", "soft after paying one", req_soft, (i < 2) ? 1 : 0);
    end
  endtask

  // R6: acknowledges without a visible request are ignored
  task automatic t_stray_ack();
    start_fresh();
    enable = 1'b1;
    wait_cyc(5);
    pulse_ack();
    chk("R6", "busy after ack at zero balance", busy, 0);
    chk("R6", "soft after ack at zero balance", req_soft, 0);
    wait_cyc(2 * IV - 6);
    chk("R6", "soft at balance 2 (no wrap)", req_soft, 1);
    chk("R6", "hard at balance 2 (no wrap)", req_hard, 0);
    pulse_ack();
    wait_cyc(1);
    pulse_ack();
    wait_cyc(TR - 2);
    chk("R6", "soft after ack inside window", req_soft, 1);
    pulse_ack();
    wait_cyc(TR);
    chk("R6", "balance empties after one more", req_soft, 0);
  endtask

  // R8: interval end and refresh on the same edge
  task automatic t_same_edge();
    start_fresh();
    enable = 1'b1;
    wait_cyc(IV);
    chk("R8", "soft at balance 1", req_soft, 1);
    wait_cyc(IV - 1);
    pulse_ack();
    wait_cyc(TR);
    chk("R8", "balance unchanged after collision", req_soft, 1);
    pulse_ack();
    wait_cyc(TR);
    chk("R8", "one refresh clears remaining balance", req_soft, 0);
  endtask

  // R9: disable clears balance and interval phase
  task automatic t_disable();
    start_fresh();
    enable = 1'b1;
    wait_cyc(2 * IV + 5);
    chk("R9", "soft at balance 2", req_soft, 1);
    enable = 1'b0;
    wait_cyc(1);
    chk("R9", "soft after disable", req_soft, 0);
    enable = 1'b1;
    wait_cyc(IV - 1);
    chk("R9", "no early interval after re-enable", req_soft, 0);
    wait_cyc(1);
    chk("R9", "interval after re-enable", req_soft, 1);
    pulse_ack();
    wait_cyc(TR);
    chk("R9", "old balance was cleared", req_soft, 0);
  endtask

  initial begin
    t_reset();
    t_fill_and_overflow();
    t_paydown();
    t_stray_ack();
    t_same_edge();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule